// File: doc/BRIEF.md
# Line-Change Timestamping Engine

The engine watches a wide bundle of asynchronous input lines and records every change of level on the lines that software has enabled. Each recorded change becomes one entry in an on-chip queue. The entry holds the index of the line, the direction of the change and the value of a free-running system counter that is supplied from outside the block. Software drains the queue through a show-ahead read port with a single pop strobe.

The enable bits are held as an array of 32-bit slices, with one bit for each line. Software writes one whole slice at a time by giving its index and a 32-bit value. If several enabled lines change in the same cycle, every change is held as pending against its own line. Pending changes go into the queue one per cycle, lowest line index first. An interrupt stays high while the queue holds at least a programmable number of entries. A sticky overflow flag records any change that was lost.

Top module: `lts_engine`

## Requirements
- R1: Each line passes through two synchronising flops before its change is detected. A change driven before rising edge k is first readable (`rd_valid` high) after edge k+3 and not earlier.
- R2: A record carries the line index (`rd_line`) and the new level (`rd_rise`: 1 for low-to-high, 0 for high-to-low). It also carries the value `sys_cnt` held at edge k+2, which is the moment the change is detected.
- R3: Line n is enabled by bit n%32 of slice n/32. A write on `en_wr` replaces the whole slice `en_slice` with `en_data` and is used for detection from the next edge onward. A cleared bit means changes on that line produce no record. A slice index of NUM_SLICES or above is ignored.
- R4: Enabled changes seen in the same cycle are all recorded. They go into the queue one per cycle, lowest line index first.
- R5: The queue is first-in first-out and shows its oldest entry on the read outputs while `rd_valid` is high. `rd_pop` removes that entry, and a pop on an empty queue has no effect.
- R6: `irq` is high exactly while occupancy is at or above the threshold, and the threshold is 1 after reset.
- R7: A write on `thr_wr` sets the threshold to `thr_data` only for values 1 to 256. The values 0 and 257 to 511 are ignored.
- R8: A pending change that reaches the queue while it is full (FIFO_DEPTH entries) is discarded and sets `ovf`. `ovf` stays high until an `ovf_clr` pulse clears it. A new loss in the same cycle as a clear wins.
- R9: If an enabled line changes again while its earlier change is still pending, the newer change replaces the pending one and `ovf` is set.
- R10: After reset the queue is empty, `irq` and `ovf` are low, and all enables are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | NUM_SLICES*32 | Monitored asynchronous lines |
| sys_cnt | input | TS_W | Free-running system counter |
| en_wr | input | 1 | Enable slice write strobe |
| en_slice | input | $clog2(NUM_SLICES) | Slice index for the enable write |
| en_data | input | 32 | New enable bits for the slice |
| thr_wr | input | 1 | Threshold write strobe |
| thr_data | input | 9 | New interrupt threshold |
| ovf_clr | input | 1 | Clears the overflow flag |
| rd_pop | input | 1 | Removes the shown record |
| rd_valid | output | 1 | Queue holds at least one record |
| rd_line | output | $clog2(NUM_SLICES*32) | Line index of the shown record |
| rd_rise | output | 1 | Level after the change of the shown record |
| rd_stamp | output | TS_W | Captured counter value of the shown record |
| irq | output | 1 | Occupancy at or above threshold |
| ovf | output | 1 | Sticky lost-change flag |

## Verification
A wrong synchroniser depth or a wrong capture point moves both the first cycle of `rd_valid` and the captured `rd_stamp` by whole cycles. That shows up at the first recorded change. A fault in arbitration or in the pending state appears as records in the wrong order, duplicated or missing. It surfaces on the first multi-line burst, and `ovf` rises either too early or not at all. Faults in the queue or in the threshold show on `irq` in the same cycle that the occupancy crosses the threshold. A reference model checks every output on every clock, so a divergence is reported in the cycle it first appears.

// File: rtl/lts_pkg.sv
// Shared constants for the line-change timestamping engine.
// Assumes: enables are always grouped in 32-bit slices.
package lts_pkg;
    localparam int SLICE_BITS = 32;   // lines per enable slice
    localparam int THR_W      = 9;    // threshold field width
    localparam int THR_MAX    = 256;  // largest legal threshold
endpackage

// File: rtl/lts_line_front.sv
// Per-line front end: two-flop synchroniser, change detector, enable mask
// and a one-deep pending record (level + stamp) per line.
// Assumes: grant is one-hot or zero and only names pending lines.
module lts_line_front #(
    parameter int N_LINES = 96,
    parameter int TS_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_LINES-1:0] line_in,
    input  logic [N_LINES-1:0] en_mask,
    input  logic [TS_W-1:0]   sys_cnt,
    input  logic [N_LINES-1:0] grant,
    output logic [N_LINES-1:0] pend,
    output logic [N_LINES-1:0] lvl,
    output logic [TS_W-1:0]   stamp [N_LINES],
    output logic              lost
);
    logic [N_LINES-1:0] sync_a;
    logic [N_LINES-1:0] sync_b;
    logic [N_LINES-1:0] hist;
    logic [N_LINES-1:0] hit;

    // Synchronise the raw lines and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a <= '0;
            sync_b <= '0;
            hist   <= '0;
        end else begin
            sync_a <= line_in;
            sync_b <= sync_a;
            hist   <= sync_b;
        end
    end

    // An enabled line whose synchronised level differs from its history.
    always_comb hit = (sync_b ^ hist) & en_mask;

    // A change that lands on a still-pending, ungranted line loses the older one.
    always_comb lost = |(hit & pend & ~grant);

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        logic            p_q;
        logic            l_q;
        logic [TS_W-1:0] s_q;

        // Hold a pending record; a new change overrides a grant in the same cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                p_q <= 1'b0;
                l_q <= 1'b0;
                s_q <= '0;
            end else if (hit[i]) begin
                p_q <= 1'b1;
                l_q <= sync_b[i];
                s_q <= sys_cnt;
            end else if (grant[i]) begin
                p_q <= 1'b0;
            end
        end

        assign pend[i]  = p_q;
        assign lvl[i]   = l_q;
        assign stamp[i] = s_q;
    end

    // R1: every detected change is pending on the following cycle.
    a_r1_hit_becomes_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> ((pend & $past(hit)) == $past(hit)));

    // R2: the level stored for a new change is the line's synchronised level.
    a_r2_level_follows_line: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> ((lvl & $past(hit)) == ($past(sync_b) & $past(hit))));
endmodule

// File: rtl/lts_pick.sv
// Fixed-priority picker: selects the lowest-index request.
// Assumes: N_LINES >= 2.
module lts_pick #(
    parameter int N_LINES = 96,
    localparam int IDX_W  = $clog2(N_LINES)
) (
    input  logic [N_LINES-1:0] req,
    output logic [N_LINES-1:0] grant,
    output logic [IDX_W-1:0]   idx,
    output logic               any
);
    // Scan from the top down so that the lowest set request is kept last.
    always_comb begin
        idx = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    // Build the one-hot grant from the chosen index.
    always_comb begin
        any   = |req;
        grant = '0;
        if (any) grant[idx] = 1'b1;
    end
endmodule

// File: rtl/lts_fifo.sv
// Show-ahead record queue with an occupancy count.
// Assumes: the caller never pushes while count == DEPTH.
module lts_fifo #(
    parameter int W     = 40,
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             pop_ok;

    // A pop only acts when something is stored.
    always_comb pop_ok = pop && (count != '0);

    // Store the pushed record.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // Advance the pointers and the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (push && !pop_ok)      count <= count + 1'b1;
            else if (!push && pop_ok) count <= count - 1'b1;
        end
    end

    // Show the oldest record.
    always_comb head = mem[rd_ptr];

    // R5: occupancy never exceeds the depth.
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R5: a pop on an empty queue leaves it empty.
    a_r5_empty_pop_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && pop && !push) |=> (count == '0));
endmodule

// File: rtl/lts_engine.sv
// Line-change timestamping engine top: slice enables, threshold, change
// arbitration into a record queue, interrupt and sticky overflow.
// Assumes: NUM_SLICES is 3, 11 or 17; FIFO_DEPTH is a power of two >= 2.
module lts_engine
    import lts_pkg::*;
#(
    parameter int NUM_SLICES = 3,
    parameter int TS_W       = 32,
    parameter int FIFO_DEPTH = 16,
    localparam int N_LINES   = NUM_SLICES * SLICE_BITS,
    localparam int LINE_W    = $clog2(N_LINES),
    localparam int SLICE_W   = $clog2(NUM_SLICES),
    localparam int REC_W     = LINE_W + 1 + TS_W,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_LINES-1:0]    line_in,
    input  logic [TS_W-1:0]       sys_cnt,
    input  logic                  en_wr,
    input  logic [SLICE_W-1:0]    en_slice,
    input  logic [SLICE_BITS-1:0] en_data,
    input  logic                  thr_wr,
    input  logic [THR_W-1:0]      thr_data,
    input  logic                  ovf_clr,
    input  logic                  rd_pop,
    output logic                  rd_valid,
    output logic [LINE_W-1:0]     rd_line,
    output logic                  rd_rise,
    output logic [TS_W-1:0]       rd_stamp,
    output logic                  irq,
    output logic                  ovf
);
    logic [N_LINES-1:0] en_q;
    logic [THR_W-1:0]   thr_q;
    logic [N_LINES-1:0] pend;
    logic [N_LINES-1:0] lvl;
    logic [TS_W-1:0]    stamp [N_LINES];
    logic [N_LINES-1:0] grant;
    logic [LINE_W-1:0]  pick_idx;
    logic               pick_any;
    logic               lost;
    logic               full;
    logic               push;
    logic               drop;
    logic [REC_W-1:0]   rec_in;
    logic [REC_W-1:0]   rec_head;
    logic [CNT_W-1:0]   fill;

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
        // Replace one enable slice when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                en_q[s*SLICE_BITS +: SLICE_BITS] <= '0;
            else if (en_wr && en_slice == SLICE_W'(s))
                en_q[s*SLICE_BITS +: SLICE_BITS] <= en_data;
        end

        // R3: a slice write lands in the addressed slice.
        a_r3_slice_write: assert property (@(posedge clk) disable iff (!rst_n)
            (en_wr && en_slice == SLICE_W'(s)) |=>
            (en_q[s*SLICE_BITS +: SLICE_BITS] == $past(en_data)));
    end

    // Accept only legal threshold values.
    always_ff @(posedge clk) begin
        if (!rst_n)
            thr_q <= THR_W'(1);
        else if (thr_wr && thr_data != '0 && thr_data <= THR_W'(THR_MAX))
            thr_q <= thr_data;
    end

    lts_line_front #(.N_LINES(N_LINES), .TS_W(TS_W)) u_front (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_in),
        .en_mask (en_q),
        .sys_cnt (sys_cnt),
        .grant   (grant),
        .pend    (pend),
        .lvl     (lvl),
        .stamp   (stamp),
        .lost    (lost)
    );

    lts_pick #(.N_LINES(N_LINES)) u_pick (
        .req   (pend),
        .grant (grant),
        .idx   (pick_idx),
        .any   (pick_any)
    );

    // Route the granted line's record to the queue, or drop it when full.
    always_comb begin
        full   = (fill == CNT_W'(FIFO_DEPTH));
        push   = pick_any && !full;
        drop   = pick_any && full;
        rec_in = {pick_idx, lvl[pick_idx], stamp[pick_idx]};
    end

    lts_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (rec_in),
        .pop       (rd_pop),
        .head      (rec_head),
        .count     (fill)
    );

    // Sticky loss flag; a new loss beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                ovf <= 1'b0;
        else if (drop || lost)     ovf <= 1'b1;
        else if (ovf_clr)          ovf <= 1'b0;
    end

    // Split the shown record and compare occupancy against the threshold.
    always_comb begin
        rd_valid = (fill != '0);
        rd_line  = rec_head[REC_W-1 -: LINE_W];
        rd_rise  = rec_head[TS_W];
        rd_stamp = rec_head[TS_W-1:0];
        irq      = (32'(fill) >= 32'(thr_q));
    end

    // R4: at most one line is granted per cycle.
    a_r4_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R4: a grant only names a pending line.
    a_r4_grant_pending: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & ~pend) == '0));

    // R7: the threshold stays inside its legal range.
    a_r7_thr_range: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_q != '0) && (thr_q <= THR_W'(THR_MAX)));

    // R8: overflow holds until cleared.
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);

    // R9: a replaced pending change raises overflow next cycle.
    a_r9_lost_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        lost |=> ovf);
endmodule

// File: tb/lts_engine_tb.sv
`timescale 1ns/1ps
module lts_engine_tb;
    localparam int NS    = 3;
    localparam int N     = NS * 32;
    localparam int DEPTH = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  line_in;
    logic [31:0]   sys_cnt;
    logic          en_wr;
    logic [1:0]    en_slice;
    logic [31:0]   en_data;
    logic          thr_wr;
    logic [8:0]    thr_data;
    logic          ovf_clr;
    logic          rd_pop;
    logic          rd_valid;
    logic [6:0]    rd_line;
    logic          rd_rise;
    logic [31:0]   rd_stamp;
    logic          irq;
    logic          ovf;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    lts_engine #(.NUM_SLICES(NS), .TS_W(32), .FIFO_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .sys_cnt(sys_cnt),
        .en_wr(en_wr), .en_slice(en_slice), .en_data(en_data),
        .thr_wr(thr_wr), .thr_data(thr_data), .ovf_clr(ovf_clr),
        .rd_pop(rd_pop), .rd_valid(rd_valid), .rd_line(rd_line),
        .rd_rise(rd_rise), .rd_stamp(rd_stamp), .irq(irq), .ovf(ovf)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [N-1:0] m_s1, m_s2, m_s3, m_en, m_pend, m_lvl, m_pend_old, m_chg;
    logic [31:0]  m_stamp [N];
    int           q_line[$];
    bit           q_lvl[$];
    logic [31:0]  q_stamp[$];
    int           m_thr;
    bit           m_ovf, m_set, m_full;
    int           m_gi;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_s3 = '0; m_en = '0; m_pend = '0; m_lvl = '0;
            q_line.delete(); q_lvl.delete(); q_stamp.delete();
            m_thr = 1; m_ovf = 0;
        end else begin
            m_pend_old = m_pend;
            m_set = 0;
            m_gi = -1;
            for (int i = 0; i < N; i++) if (m_pend[i] && m_gi < 0) m_gi = i;
            m_full = (q_line.size() == DEPTH);
            if (rd_pop && q_line.size() > 0) begin
                void'(q_line.pop_front()); void'(q_lvl.pop_front()); void'(q_stamp.pop_front());
            end
            if (m_gi >= 0) begin
                m_pend[m_gi] = 0;
                if (m_full) m_set = 1;
                else begin
                    q_line.push_back(m_gi); q_lvl.push_back(m_lvl[m_gi]);
                    q_stamp.push_back(m_stamp[m_gi]);
                end
            end
            m_chg = (m_s2 ^ m_s3) & m_en;
            for (int i = 0; i < N; i++) begin
                if (m_chg[i]) begin
                    if (m_pend_old[i] && i != m_gi) m_set = 1;
                    m_pend[i] = 1; m_lvl[i] = m_s2[i]; m_stamp[i] = sys_cnt;
                end
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = line_in;
            if (en_wr && en_slice < NS) m_en[en_slice*32 +: 32] = en_data;
            if (thr_wr && thr_data >= 1 && thr_data <= 256) m_thr = thr_data;
            if (m_set) m_ovf = 1; else if (ovf_clr) m_ovf = 0;
        end
    end

    // Compare every output just after each edge.
    always begin
        @(posedge clk); #1;
        if (!done) begin
            chk("R5 rd_valid", rd_valid, q_line.size() > 0);
            if (q_line.size() > 0) begin
                chk("R2 rd_line", rd_line, q_line[0]);
                chk("R2 rd_rise", rd_rise, q_lvl[0]);
                chk("R2 rd_stamp", rd_stamp, q_stamp[0]);
            end
            chk("R6 irq", irq, q_line.size() >= m_thr);
            chk("R8 ovf", ovf, m_ovf);
        end
    end

    // ---------------- stimulus helpers ----------------
    initial begin
        sys_cnt = 32'd100;
        forever begin
            @(negedge clk);
            sys_cnt = sys_cnt + 32'd7;
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_en(input int s, input logic [31:0] d);
        @(negedge clk); en_wr = 1; en_slice = 2'(s); en_data = d;
        @(negedge clk); en_wr = 0;
    endtask

    task automatic wr_thr(input int v);
        @(negedge clk); thr_wr = 1; thr_data = 9'(v);
        @(negedge clk); thr_wr = 0;
    endtask

    task automatic pop1();
        @(negedge clk); rd_pop = 1;
        @(negedge clk); rd_pop = 0;
    endtask

    task automatic drain(output int cnt, output int last_line, output bit last_rise);
        cnt = 0; last_line = -1; last_rise = 0;
        while (rd_valid && cnt < 40) begin
            last_line = rd_line; last_rise = rd_rise;
            pop1(); cnt++;
        end
    endtask

    task automatic finish_up();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_up();
    end

    // ---------------- directed and random sequence ----------------
    initial begin
        int cnt, ll;
        bit lr;
        rst_n = 0; line_in = '0; en_wr = 0; en_slice = '0; en_data = '0;
        thr_wr = 0; thr_data = '0; ovf_clr = 0; rd_pop = 0;
        wait_n(4);
        rst_n = 1;
        wait_n(1);
        chk("R10 empty", rd_valid, 0);
        chk("R10 irq", irq, 0);
        chk("R10 ovf", ovf, 0);

        // R10: enables start cleared, so a change is not recorded.
        @(negedge clk); line_in[3] = 1;
        wait_n(6);
        chk("R10 no record with reset enables", rd_valid, 0);

        wr_en(0, 32'hFFFF_FFFF);
        wr_en(1, 32'h0000_FFFF);
        wr_en(2, 32'hFFFF_0000);
        wr_en(3, 32'hFFFF_FFFF);   // R3: out-of-range slice is ignored

        // R3: disabled line 50 yields nothing.
        @(negedge clk); line_in[50] = 1;
        wait_n(6);
        chk("R3 disabled line", rd_valid, 0);

        // R1: latency of a single change on line 5.
        @(negedge clk); line_in[5] = 1;
        wait_n(3);
        chk("R1 not before edge k+3", rd_valid, 0);
        wait_n(1);
        chk("R1 record at edge k+3", rd_valid, 1);
        chk("R2 line index", rd_line, 5);
        chk("R2 rising", rd_rise, 1);
        chk("R6 default threshold", irq, 1);
        pop1();
        chk("R5 popped", rd_valid, 0);
        chk("R6 irq drops", irq, 0);
        pop1();
        chk("R5 empty pop inert", rd_valid, 0);
        chk("R5 empty pop ovf", ovf, 0);

        // R4: simultaneous changes, lowest index first.
        @(negedge clk); line_in[40] = 1; line_in[7] = 1; line_in[85] = 1;
        wait_n(7);
        chk("R4 first", rd_line, 7);  pop1();
        chk("R4 second", rd_line, 40); pop1();
        chk("R4 third", rd_line, 85);
        chk("R2 falling? no, rising", rd_rise, 1);
        pop1();

        // R7: illegal thresholds ignored, legal one taken.
        wr_thr(0);
        wr_thr(300);
        @(negedge clk); line_in[1] = 1;
        wait_n(5);
        chk("R7 threshold still 1", irq, 1);
        wr_thr(3);
        wait_n(1);
        chk("R7 threshold 3 one entry", irq, 0);
        @(negedge clk); line_in[2] = 1; line_in[3] = 0;
        wait_n(6);
        chk("R6 three entries", irq, 1);
        pop1();
        chk("R6 below threshold", irq, 0);
        drain(cnt, ll, lr);
        wr_thr(1);

        // R8: burst of 20 into a 16-deep queue.
        @(negedge clk);
        for (int i = 8; i < 28; i++) line_in[i] = ~line_in[i];
        wait_n(30);
        chk("R8 overflow set", ovf, 1);
        drain(cnt, ll, lr);
        chk("R8 stored entries", cnt, 16);
        chk("R8 still sticky", ovf, 1);
        @(negedge clk); ovf_clr = 1;
        @(negedge clk); ovf_clr = 0;
        chk("R8 cleared", ovf, 0);

        // R9: second change on a pending line replaces it.
        @(negedge clk);
        for (int i = 28; i < 43; i++) line_in[i] = ~line_in[i];
        line_in[90] = 1;
        wait_n(2);
        line_in[90] = 0;
        wait_n(30);
        chk("R9 overflow on replace", ovf, 1);
        drain(cnt, ll, lr);
        chk("R9 entry count", cnt, 16);
        chk("R9 last line", ll, 90);
        chk("R9 newer level kept", lr, 0);
        @(negedge clk); ovf_clr = 1;
        @(negedge clk); ovf_clr = 0;

        // Mixed traffic checked by the model.
        for (int c = 0; c < 600; c++) begin
            @(negedge clk);
            rd_pop = ($urandom_range(0, 2) != 0);
            ovf_clr = ($urandom_range(0, 40) == 0);
            if ($urandom_range(0, 3) == 0) line_in[$urandom_range(0, N - 1)] ^= 1'b1;
            if ($urandom_range(0, 15) == 0)
                for (int k = 0; k < 6; k++) line_in[$urandom_range(0, N - 1)] ^= 1'b1;
            en_wr = ($urandom_range(0, 60) == 0);
            en_slice = 2'($urandom_range(0, 3));
            en_data = $urandom;
            thr_wr = ($urandom_range(0, 50) == 0);
            thr_data = 9'($urandom_range(0, 511));
        end
        @(negedge clk);
        rd_pop = 0; ovf_clr = 0; en_wr = 0; thr_wr = 0;
        wait_n(3);
        finish_up();
    end
endmodule